// File: doc/BRIEF.md
# Serial Converter Command Front End

This block is the command and sequencing logic of a serially controlled sampling converter. It oversamples chip select, serial clock and data-in on the system clock. It finds a start bit in the data stream and shifts in a control byte MSB first. From that byte it launches either a conversion or a calibration. Counters of parameter length stand in for the analog core. A status strobe marks the busy period, and its polarity depends on the selected clocking mode.

A command is framed only by the first high bit sampled on data-in, never by the chip-select edge itself. While an operation runs, further high bits are ignored. The one exception is a new start bit that follows a chip-select high pulse: it abandons the current operation and opens a new command. The three programmable bits and the clock-mode flag are visible at the ports.

Top module: `adc_cmd_frontend`

## Requirements
- R1: A falling chip-select edge alone, or low bits sampled while chip select is low, leaves the block idle (status 0).
- R2: Serial clock and data-in activity while chip select is high has no effect: the status stays idle and the programmable bits stay unchanged.
- R3: Data-in is sampled on serial-clock rising edges, MSB first. The first high bit is the start bit (byte bit 7). Bits 6..4 load the programmable bits `prog_bits[2:0]` and bits 3..2 are the mode field {M1,M0}. Bits 1..0 are reserved.
- R4: The operation begins on the serial-clock falling edge that follows the seventh bit. Until that edge the status reads shifting.
- R5: After reset, status is idle, `prog_bits` is 0 (bipolar), `ext_clk_mode` is 0 (internal clocking) and `strobe` is 1.
- R6: Mode 01 starts a calibration lasting CAL_LEN clock cycles and leaves the clock mode unchanged. Any other mode starts a conversion lasting CONV_LEN cycles. Mode 11 selects external clocking, and modes 00 and 10 select internal clocking.
- R7: In internal clock mode, `strobe` is low for exactly the busy cycles and high when idle.
- R8: In external clock mode, `strobe` is high for exactly the busy cycles and low when idle.
- R9: A chip-select high pulse followed by a start bit during an operation abandons that operation. The new command then runs to completion.
- R10: High bits on data-in during an operation, with no chip-select pulse, are ignored: the operation keeps its full length and the programmable bits do not change.
- R11: Status encoding: 0 idle, 1 shifting, 2 converting, 3 calibrating.
- R12: Chip select rising during shifting discards the partial command. The status returns to idle and the programmable bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| strobe | output | 1 | Busy strobe; polarity set by clock mode |
| status | output | 2 | 0 idle, 1 shifting, 2 converting, 3 calibrating |
| prog_bits | output | 3 | Programmable bits from the last accepted command |
| ext_clk_mode | output | 1 | 1 when external clocking is selected |

## Verification
The bench targets the start-bit rules first. A block that started on the chip-select edge, or that accepted low bits, would leave idle during the leading-zero and select-only stimulus. A block that did not gate busy-time bits would lengthen or restart a calibration. It also checks the status just before the seventh falling edge. A block that launched on the rising edge, or one bit early, would already report converting at that point. Strobe active cycles are counted in both clock modes, including a calibration that must keep the prior mode, so a swapped polarity or an off-by-one timer shows as a wrong count. The abort and partial-frame cases show whether the old operation truly ends and whether a discarded frame leaks into the programmable bits.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_CONV  = 2'd2,
      ST_CAL   = 2'd3
   } fe_state_t;

   typedef struct packed {
      logic [2:0] prog;
      logic [1:0] mode;
   } cmd_t;

   localparam int FIELD_BITS = $bits(cmd_t);
   localparam int CMD_BITS   = FIELD_BITS + 2;
   localparam logic [1:0] MODE_CAL    = 2'b01;
   localparam logic [1:0] MODE_EXTCLK = 2'b11;

endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/fe_shifter.sv
module fe_shifter
   import adc_cmd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_l,
   input  logic sclk_l,
   input  logic din_l,
   input  logic busy,
   output logic start_p,
   output logic cmd_valid,
   output cmd_t cmd,
   output logic shifting
);
   localparam int CW = $clog2(CMD_BITS + 1);

   logic                  sclk_prev;
   logic                  armed;
   logic [CW-1:0]         cnt;
   logic [FIELD_BITS-1:0] sr;
   logic                  sclk_rise, sclk_fall;

   assign sclk_rise = sclk_l & ~sclk_prev;
   assign sclk_fall = ~sclk_l & sclk_prev;
   assign start_p   = !cs_l && !shifting && sclk_rise && din_l && (!busy || armed);
   assign cmd_valid = !cs_l && shifting && sclk_fall && (cnt == CW'(CMD_BITS));
   assign cmd       = cmd_t'(sr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         shifting  <= 1'b0;
         armed     <= 1'b1;
         cnt       <= '0;
         sr        <= '0;
      end else begin
         sclk_prev <= sclk_l;
         if (cs_l) begin
            shifting <= 1'b0;
            cnt      <= '0;
            armed    <= 1'b1;
         end else if (start_p) begin
            shifting <= 1'b1;
            cnt      <= CW'(1);
            sr       <= '0;
            armed    <= 1'b0;
         end else if (cmd_valid) begin
            shifting <= 1'b0;
         end else if (shifting && sclk_rise) begin
            cnt <= cnt + 1'b1;
            if (cnt <= CW'(FIELD_BITS)) sr <= {sr[FIELD_BITS-2:0], din_l};
         end
      end
   end

   AST_CS_HIGH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      cs_l |=> !shifting); // R2
   AST_START_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shifting) |-> $past(din_l)); // R3
   AST_BUSY_GATES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !armed && !shifting) |=> !shifting); // R10
endmodule

// File: rtl/fe_seq.sv
module fe_seq
   import adc_cmd_pkg::*;
#(
   parameter int unsigned CONV_LEN = 64,
   parameter int unsigned CAL_LEN  = 80000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_p,
   input  logic      cmd_valid,
   input  cmd_t      cmd,
   output fe_state_t op,
   output logic      ext_clk,
   output logic [2:0] prog,
   output logic      strobe
);
   localparam int unsigned MAXLEN = (CAL_LEN > CONV_LEN) ? CAL_LEN : CONV_LEN;
   localparam int          TW     = $clog2(MAXLEN) + 1;

   fe_state_t   op_n;
   logic [TW-1:0] tmr, tmr_n;
   logic        ext_n, busy_n, strobe_n;
   logic [2:0]  prog_n;

   always_comb begin
      op_n   = op;
      tmr_n  = tmr;
      ext_n  = ext_clk;
      prog_n = prog;
      if (cmd_valid) begin
         prog_n = cmd.prog;
         if (cmd.mode == MODE_CAL) begin
            op_n  = ST_CAL;
            tmr_n = TW'(CAL_LEN - 1);
         end else begin
            op_n  = ST_CONV;
            tmr_n = TW'(CONV_LEN - 1);
            ext_n = (cmd.mode == MODE_EXTCLK);
         end
      end else if (start_p) begin
         op_n = ST_IDLE;
      end else if (op != ST_IDLE) begin
         if (tmr == '0) op_n = ST_IDLE;
         else           tmr_n = tmr - 1'b1;
      end
      busy_n   = (op_n != ST_IDLE);
      strobe_n = ext_n ? busy_n : !busy_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op      <= ST_IDLE;
         tmr     <= '0;
         ext_clk <= 1'b0;
         prog    <= '0;
         strobe  <= 1'b1;
      end else begin
         op      <= op_n;
         tmr     <= tmr_n;
         ext_clk <= ext_n;
         prog    <= prog_n;
         strobe  <= strobe_n;
      end
   end

   AST_CMD_STARTS_OP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> (op != ST_IDLE)); // R4
   AST_CAL_KEEPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd.mode == MODE_CAL) |=> $stable(ext_clk)); // R6
   AST_START_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> (op == ST_IDLE)); // R9
   AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (op != ST_IDLE) |-> (tmr < TW'(MAXLEN))); // R6
endmodule

// File: rtl/adc_cmd_frontend.sv
module adc_cmd_frontend
   import adc_cmd_pkg::*;
#(
   parameter int unsigned CONV_LEN    = 64,
   parameter int unsigned CAL_LEN     = 80000,
   parameter int          SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sclk,
   input  logic       din,
   output logic       strobe,
   output logic [1:0] status,
   output logic [2:0] prog_bits,
   output logic       ext_clk_mode
);
   generate
      if (CONV_LEN < 1 || CAL_LEN < 1) begin : g_bad_len
         $error("operation lengths must be at least one cycle");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [2:0] pins_l;
   logic       cs_l, sclk_l, din_l;
   logic       start_p, cmd_valid, shifting;
   cmd_t       cmd;
   fe_state_t  op;

   fe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, din}), .q(pins_l));

   assign {cs_l, sclk_l, din_l} = pins_l;

   fe_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .cs_l(cs_l), .sclk_l(sclk_l), .din_l(din_l),
      .busy(op != ST_IDLE), .start_p(start_p), .cmd_valid(cmd_valid),
      .cmd(cmd), .shifting(shifting));

   fe_seq #(.CONV_LEN(CONV_LEN), .CAL_LEN(CAL_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_p(start_p), .cmd_valid(cmd_valid),
      .cmd(cmd), .op(op), .ext_clk(ext_clk_mode), .prog(prog_bits),
      .strobe(strobe));

   assign status = shifting ? ST_SHIFT : op;

   AST_IDLE_STROBE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (status == ST_IDLE) |-> (strobe != ext_clk_mode)); // R7
   AST_BUSY_STROBE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (status == ST_CONV || status == ST_CAL) |-> (strobe == ext_clk_mode)); // R8
endmodule

// File: tb/sim_adc_cmd_frontend.sv
module sim_adc_cmd_frontend;
   localparam int CONV = 40;
   localparam int CAL  = 200;
   localparam int HALF = 4;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
   logic strobe, ext_clk_mode;
   logic [1:0] status;
   logic [2:0] prog_bits;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int conv_cnt = 0, cal_cnt = 0, stb_cnt = 0;
   logic exp_ext = 1'b0;
   logic [2:0] exp_prog = 3'd0;

   always #4 clk = ~clk;

   adc_cmd_frontend #(.CONV_LEN(CONV), .CAL_LEN(CAL), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .strobe(strobe), .status(status), .prog_bits(prog_bits),
      .ext_clk_mode(ext_clk_mode));

   always @(negedge clk) begin
      cyc++;
      if (status == 2'd2) conv_cnt++;
      if (status == 2'd3) cal_cnt++;
      if ((status == 2'd2 || status == 2'd3) && strobe == exp_ext) stb_cnt++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic v);
      din = v; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2 * CAL + 100; i++) begin
         if (status == 2'd0) break;
         tick(1);
      end
      chk(status == 2'd0, "R6 wait idle", int'(status), 0);
   endtask

   function automatic logic next_ext(input logic [1:0] m, input logic cur);
      if (m == 2'b01) return cur;
      return (m == 2'b11);
   endfunction

   task automatic frame(input logic [7:0] b, input int zeros, input int extra);
      bit is_cal;
      int len;
      is_cal = (b[3:2] == 2'b01);
      len = is_cal ? CAL : CONV;
      exp_ext = next_ext(b[3:2], exp_ext);
      conv_cnt = 0; cal_cnt = 0; stb_cnt = 0;
      cs_n = 1'b0; tick(HALF);
      for (int z = 0; z < zeros; z++) send_bit(1'b0);
      for (int i = 7; i >= 1; i--) begin
         din = b[i]; tick(HALF); sclk = 1'b1; tick(HALF);
         if (i == 1) chk(status == 2'd1, "R4 shifting before 7th fall", int'(status), 1);
         sclk = 1'b0;
      end
      tick(6);
      chk(int'(status) == (is_cal ? 3 : 2), "R11 busy code", int'(status), is_cal ? 3 : 2);
      send_bit(b[0]);
      for (int k = 0; k < extra; k++) send_bit(1'b1);
      if (extra > 0) chk(int'(status) == (is_cal ? 3 : 2), "R10 busy kept", int'(status), is_cal ? 3 : 2);
      wait_idle();
      exp_prog = b[6:4];
      chk(prog_bits == exp_prog, "R3 prog bits", int'(prog_bits), int'(exp_prog));
      chk(ext_clk_mode == exp_ext, "R6 clock mode", int'(ext_clk_mode), int'(exp_ext));
      chk((is_cal ? cal_cnt : conv_cnt) == len, "R6 op length", is_cal ? cal_cnt : conv_cnt, len);
      chk(stb_cnt == len, exp_ext ? "R8 strobe active cycles" : "R7 strobe active cycles", stb_cnt, len);
      chk(strobe == !exp_ext, exp_ext ? "R8 idle level" : "R7 idle level", int'(strobe), int'(!exp_ext));
      cs_n = 1'b1; din = 1'b0; tick(HALF);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      tick(5); rst_n = 1'b1; tick(5);
      // R5 reset defaults
      chk(status == 2'd0, "R5 status", int'(status), 0);
      chk(strobe == 1'b1, "R5 strobe", int'(strobe), 1);
      chk(prog_bits == 3'd0, "R5 prog", int'(prog_bits), 0);
      chk(ext_clk_mode == 1'b0, "R5 ext", int'(ext_clk_mode), 0);

      // R1 select edge alone and low bits
      cs_n = 1'b0; tick(20);
      chk(status == 2'd0, "R1 cs fall alone", int'(status), 0);
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); tick(6);
      chk(status == 2'd0, "R1 low bits", int'(status), 0);
      cs_n = 1'b1; tick(HALF);

      // R2 traffic while deselected
      for (int i = 0; i < 8; i++) send_bit(1'b1);
      tick(6);
      chk(status == 2'd0, "R2 status", int'(status), 0);
      chk(prog_bits == 3'd0, "R2 prog", int'(prog_bits), 0);

      frame(8'hD0, 2, 0);  // conversion, internal clock
      frame(8'hB4, 0, 0);  // calibration, internal clock
      frame(8'h8C, 1, 0);  // conversion, external clock
      frame(8'hF4, 3, 3);  // calibration keeps external, R10 extra bits

      // R12 partial frame discarded
      cs_n = 1'b0; tick(HALF);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      cs_n = 1'b1; tick(6);
      chk(status == 2'd0, "R12 status", int'(status), 0);
      chk(prog_bits == 3'd7, "R12 prog kept", int'(prog_bits), 7);

      // R9 abort calibration with a new conversion
      conv_cnt = 0; cal_cnt = 0;
      cs_n = 1'b0; tick(HALF);
      for (int i = 7; i >= 0; i--) send_bit(logic'((8'hE4 >> i) & 8'h01));
      tick(20);
      chk(status == 2'd3, "R9 calibrating", int'(status), 3);
      cs_n = 1'b1; tick(HALF); cs_n = 1'b0; tick(HALF);
      send_bit(1'b1); tick(2);
      chk(status == 2'd1, "R9 shifting after abort", int'(status), 1);
      for (int i = 6; i >= 0; i--) send_bit(logic'((8'h9C >> i) & 8'h01));
      wait_idle();
      chk(conv_cnt == CONV, "R9 new op length", conv_cnt, CONV);
      chk(cal_cnt < CAL, "R9 old op cut", cal_cnt, CAL - 1);
      chk(prog_bits == 3'd1, "R9 prog", int'(prog_bits), 1);
      cs_n = 1'b1; tick(HALF);

      // random commands
      for (int r = 0; r < 10; r++) begin
         logic [7:0] b;
         b = {1'b1, 3'($urandom % 8), 2'($urandom % 4), 2'($urandom % 4)};
         frame(b, int'($urandom % 4), int'($urandom % 2));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule